// File: doc/BRIEF.md
# Single-Buffered Serial Port Flag Controller

This block holds the software-visible registers and status flags of an asynchronous serial port that has one byte of transmit buffering and one byte of receive buffering. A byte-wide register bus reads and writes six registers: mode, bit rate, control, transmit data, status and receive data. Bytes leave the block on a one-cycle valid strobe with 8-bit data, and received bytes enter it on a valid strobe with 8-bit data. Bit shifting and baud timing live in a separate serializer.

The status register follows a read-before-clear discipline. A flag can be cleared by writing zero to it only after software has read the status register and seen that flag set. Flags software has not yet seen survive a write of zero, and no write can set a flag. A per-bit "seen" mask records what software has observed. A status read ORs the current flags into the mask, and a status write ANDs the written value into it. A transmission starts when software clears the transmit-empty flag. The buffered byte is then handed out, and transmit-empty and transmit-end are set again.

Register map (bus address): 0 mode, 1 bit rate, 2 control, 3 transmit data, 4 status, 5 receive data. Addresses 6 and 7 are unmapped. Reads return data combinationally in the cycle of the request. Writes and read side effects take effect at the clock edge that ends that cycle.

Top module: `sbsc_ctrl`

## Requirements
- R1: After reset the status register reads 0x84 (transmit-empty bit 7 and transmit-end bit 2 set), the mode, bit-rate, control and transmit-data registers read 0x00, and tx_valid_o is low.
- R2: The status register layout is: bit 7 transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bit 2 transmit-end, bit 1 multiprocessor bit, bit 0 multiprocessor bit transfer. Bits 4, 3 and 1 have no source in this block and read 0.
- R3: Writing 0 to a status bit among bits 7..2 clears that bit only if a status read returned it set and no status write since then has written 0 to it. Otherwise the bit keeps its value.
- R4: A status write never sets bits 7..1. Bit 0 takes the written bit 0 directly.
- R5: A status write that writes 1 to a bit leaves that bit's read credit in place. A write of 0 to the bit consumes the credit.
- R6: While control bit 5 (transmit enable) is 0, a status write clears neither transmit-empty nor transmit-end, and no byte is handed off.
- R7: Writing the transmit-data register stores the byte and clears transmit-end.
- R8: When a status write clears transmit-empty, tx_valid_o is high for exactly the next cycle with tx_data_o equal to the stored transmit byte. Afterwards transmit-empty and transmit-end both read set.
- R9: A received byte that arrives while receive-full is clear is stored, and receive-full (bit 6) is set. Reading the receive-data register returns the byte and clears receive-full.
- R10: A received byte that arrives while receive-full is set is dropped, the overrun flag (bit 5) is set, and the stored byte is unchanged.
- R11: Mode, bit-rate, control and transmit-data registers read back the last value written. Unmapped addresses read 0, and writes to them, or to the receive-data register, have no effect.
- R12: Transmit-end is never set while transmit-empty is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the request cycle |
| tx_valid_o | output | 1 | One-cycle strobe handing a byte to the serializer |
| tx_data_o | output | 8 | Byte handed to the serializer |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |

## Verification
If the seen mask holds a wrong value, it shows only on a later status write. A flag then survives a write of zero that should clear it, or clears when it should not, and the next status read shows the difference. A missing clear of transmit-empty appears one cycle later as an absent or extra tx_valid_o pulse. A wrong receive-full value shows as a lost byte or a spurious overrun bit on the next status read. The bench compares read data and the transmit strobe with a reference model on every cycle, so any divergence is caught at the first access that exposes it.

// File: rtl/sbsc_pkg.sv
package sbsc_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_MODE = 3'd0,
    A_RATE = 3'd1,
    A_CTL  = 3'd2,
    A_TXD  = 3'd3,
    A_STAT = 3'd4,
    A_RXD  = 3'd5
  } reg_sel_e;

  localparam int B_TDRE = 7;
  localparam int B_RDRF = 6;
  localparam int B_ORER = 5;
  localparam int B_FERR = 4;
  localparam int B_PERR = 3;
  localparam int B_TEND = 2;
  localparam int B_MPB  = 1;
  localparam int B_MPBT = 0;

  localparam int C_TXEN = 5;

  localparam logic [DW-1:0] ST_RESET  = DW'(8'h84);
  localparam logic [DW-1:0] TX_FORCE  = DW'(8'h84);
endpackage

// File: rtl/sbsc_cfg_regs.sv
module sbsc_cfg_regs
  import sbsc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] rate_o,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] txd_o,
  output logic          txd_wr_o
);
  logic [DW-1:0] mode_q, rate_q, ctl_q, txd_q;

  assign txd_wr_o = wr_i && (addr_i == A_TXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rate_q <= '0;
      ctl_q  <= '0;
      txd_q  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_MODE:  mode_q <= wdata_i;
        A_RATE:  rate_q <= wdata_i;
        A_CTL:   ctl_q  <= wdata_i;
        A_TXD:   txd_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign rate_o = rate_q;
  assign ctl_o  = ctl_q;
  assign txd_o  = txd_q;

  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctl_q) && $stable(mode_q) && $stable(rate_q) && $stable(txd_q));
endmodule

// File: rtl/sbsc_rx_buf.sv
module sbsc_rx_buf
  import sbsc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          full_i,
  output logic          store_o,
  output logic          ovr_o,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] data_q;

  assign store_o = rx_valid_i && !full_i;
  assign ovr_o   = rx_valid_i && full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (store_o) data_q <= rx_data_i;
  end

  assign data_o = data_q;

  // R9
  rx_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !full_i |=> data_q == $past(rx_data_i));
  // R10
  rx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && full_i |=> $stable(data_q));
endmodule

// File: rtl/sbsc_status.sv
module sbsc_status
  import sbsc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_stat_i,
  input  logic          wr_stat_i,
  input  logic          rd_rx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tx_en_i,
  input  logic          txd_wr_i,
  input  logic          rx_store_i,
  input  logic          rx_ovr_i,
  output logic [DW-1:0] flags_o,
  output logic          handoff_o
);
  logic [DW-1:0] st_q, st_d, seen_q, seen_d, wv, st_w;
  logic          handoff;

  always_comb begin
    wv      = tx_en_i ? wdata_i : (wdata_i | TX_FORCE);
    st_w    = st_q & (wv | ~seen_q);
    st_d    = st_q;
    seen_d  = seen_q;
    handoff = 1'b0;
    if (rd_stat_i) seen_d = seen_q | st_q;
    if (wr_stat_i) begin
      st_d[DW-1:B_TEND] = st_w[DW-1:B_TEND];
      st_d[B_MPBT]      = wdata_i[B_MPBT];
      seen_d            = seen_q & wv;
      if (!st_d[B_TDRE]) begin
        // clearing tdre launches the buffered byte and re-arms both tx flags
        handoff      = 1'b1;
        st_d[B_TDRE] = 1'b1;
        st_d[B_TEND] = 1'b1;
      end
    end
    if (txd_wr_i)   st_d[B_TEND] = 1'b0;
    if (rd_rx_i)    st_d[B_RDRF] = 1'b0;
    if (rx_store_i) st_d[B_RDRF] = 1'b1;
    if (rx_ovr_i)   st_d[B_ORER] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RESET;
      seen_q <= '0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end

  assign flags_o   = st_q;
  assign handoff_o = handoff;

  // R12
  tend_needs_tdre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[B_TEND] |-> st_q[B_TDRE]);
  // R6
  txen_off_tdre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && !tx_en_i |=> st_q[B_TDRE]);
  // R6
  txen_off_tend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && !tx_en_i && st_q[B_TEND] |=> st_q[B_TEND]);
  // R10
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_i |=> st_q[B_ORER]);
  // R4
  no_set_rdrf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && !rx_store_i && !st_q[B_RDRF] |=> !st_q[B_RDRF]);
  // R4
  no_set_orer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && !rx_ovr_i && !st_q[B_ORER] |=> !st_q[B_ORER]);
  // R3
  unseen_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && !seen_q[B_ORER] && st_q[B_ORER] |=> st_q[B_ORER]);
  // R2
  idle_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_q[B_FERR] && !st_q[B_PERR] && !st_q[B_MPB]);
endmodule

// File: rtl/sbsc_ctrl.sv
module sbsc_ctrl
  import sbsc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i
);
  logic          wr, rd, rd_stat, wr_stat, rd_rx, txd_wr, handoff;
  logic          rx_store, rx_ovr;
  logic [DW-1:0] mode, rate, ctl, txd, flags, rx_byte;
  logic          tx_valid_q;
  logic [DW-1:0] tx_data_q;

  assign wr      = bus_req_i && bus_we_i;
  assign rd      = bus_req_i && !bus_we_i;
  assign rd_stat = rd && (bus_addr_i == A_STAT);
  assign wr_stat = wr && (bus_addr_i == A_STAT);
  assign rd_rx   = rd && (bus_addr_i == A_RXD);

  sbsc_cfg_regs u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .mode_o   (mode),
    .rate_o   (rate),
    .ctl_o    (ctl),
    .txd_o    (txd),
    .txd_wr_o (txd_wr)
  );

  sbsc_rx_buf u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .full_i     (flags[B_RDRF]),
    .store_o    (rx_store),
    .ovr_o      (rx_ovr),
    .data_o     (rx_byte)
  );

  sbsc_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_stat_i  (rd_stat),
    .wr_stat_i  (wr_stat),
    .rd_rx_i    (rd_rx),
    .wdata_i    (bus_wdata_i),
    .tx_en_i    (ctl[C_TXEN]),
    .txd_wr_i   (txd_wr),
    .rx_store_i (rx_store),
    .rx_ovr_i   (rx_ovr),
    .flags_o    (flags),
    .handoff_o  (handoff)
  );

  always_comb begin
    case (bus_addr_i)
      A_MODE:  bus_rdata_o = mode;
      A_RATE:  bus_rdata_o = rate;
      A_CTL:   bus_rdata_o = ctl;
      A_TXD:   bus_rdata_o = txd;
      A_STAT:  bus_rdata_o = flags;
      A_RXD:   bus_rdata_o = rx_byte;
      default: bus_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= handoff;
      if (handoff) tx_data_q <= txd;
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;

  // R8
  tx_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o);
  // R8
  tx_needs_txen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(ctl[C_TXEN]) && $past(wr_stat));
endmodule

// File: tb/sbsc_ctrl_tb_top.sv
module sbsc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, rxv = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rxd = '0;
  logic [7:0] rdata, txd;
  logic       txv;

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  logic [7:0] last_rd, last_txd;
  logic       last_txv;

  sbsc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tx_valid_o(txv), .tx_data_o(txd), .rx_valid_i(rxv), .rx_data_i(rxd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [7:0] m_st, m_seen, m_mode, m_rate, m_ctl, m_tdr, m_rbuf, m_txd;
  logic       m_txv;

  function automatic logic [7:0] m_rdata();
    case (addr)
      3'd0: return m_mode;
      3'd1: return m_rate;
      3'd2: return m_ctl;
      3'd3: return m_tdr;
      3'd4: return m_st;
      3'd5: return m_rbuf;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 8'h84; m_seen = 0; m_mode = 0; m_rate = 0; m_ctl = 0;
      m_tdr = 0; m_rbuf = 0; m_txd = 0; m_txv = 0;
    end else begin
      logic full_before;
      logic [7:0] v;
      full_before = m_st[6];
      m_txv = 1'b0;
      if (req && !we) begin
        if (addr == 3'd4) m_seen = m_seen | m_st;
        if (addr == 3'd5) m_st[6] = 1'b0;
      end
      if (req && we) begin
        case (addr)
          3'd0: m_mode = wdata;
          3'd1: m_rate = wdata;
          3'd2: m_ctl  = wdata;
          3'd3: begin m_tdr = wdata; m_st[2] = 1'b0; end
          3'd4: begin
            v = m_ctl[5] ? wdata : (wdata | 8'h84);
            for (int b = 2; b < 8; b++)
              if (!v[b] && m_seen[b]) m_st[b] = 1'b0;
            m_st[0] = wdata[0];
            m_seen = m_seen & v;
            if (!m_st[7]) begin
              m_txv = 1'b1; m_txd = m_tdr; m_st[7] = 1'b1; m_st[2] = 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (rxv) begin
        if (full_before) m_st[5] = 1'b1;
        else begin m_rbuf = rxd; m_st[6] = 1'b1; end
      end
    end
  end

  task automatic check(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", r, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, rdata, m_rdata());
      check(cur_req, {7'd0, txv}, {7'd0, m_txv});
      check(cur_req, txd, m_txd);
    end
  end

  task automatic op(logic q, logic w, logic [2:0] a, logic [7:0] d, logic v, logic [7:0] r);
    @(posedge clk); #1;
    req = q; we = w; addr = a; wdata = d; rxv = v; rxd = r;
    @(negedge clk); #1;
    last_rd = rdata; last_txv = txv; last_txd = txd;
  endtask

  task automatic idle();            op(0, 0, 3'd0, 8'h00, 0, 8'h00); endtask
  task automatic wr(logic [2:0] a, logic [7:0] d); op(1, 1, a, d, 0, 8'h00); endtask
  task automatic rx(logic [7:0] d); op(0, 0, 3'd0, 8'h00, 1, d); endtask
  task automatic rd(logic [2:0] a, logic [7:0] exp, string r);
    op(1, 0, a, 8'h00, 0, 8'h00);
    check(r, last_rd, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    idle();
    check("R1", {7'd0, last_txv}, 8'h00);
    rd(3'd0, 8'h00, "R1");
    rd(3'd2, 8'h00, "R1");
    rd(3'd3, 8'h00, "R1");
    // R11 readback and unmapped space
    cur_req = "R11";
    wr(3'd2, 8'h20); wr(3'd0, 8'h5A); wr(3'd1, 8'h33); wr(3'd7, 8'hFF); wr(3'd5, 8'h77);
    rd(3'd2, 8'h20, "R11");
    rd(3'd0, 8'h5A, "R11");
    rd(3'd1, 8'h33, "R11");
    rd(3'd7, 8'h00, "R11");
    rd(3'd5, 8'h00, "R11");
    // R3 write of zero with no prior read keeps flags; R4 bit0 direct
    cur_req = "R3";
    wr(3'd4, 8'h01);
    idle();
    check("R3", {7'd0, last_txv}, 8'h00);
    rd(3'd4, 8'h85, "R3");
    // R7 transmit data write clears tend
    cur_req = "R7";
    wr(3'd3, 8'hA5);
    rd(3'd4, 8'h81, "R7");
    rd(3'd3, 8'hA5, "R7");
    // R4/R5 writing ones sets nothing and keeps credit
    cur_req = "R5";
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h81, "R4");
    wr(3'd4, 8'h7E);
    // R8 handoff
    cur_req = "R8";
    idle();
    check("R8", {7'd0, last_txv}, 8'h01);
    check("R8", last_txd, 8'hA5);
    idle();
    check("R8", {7'd0, last_txv}, 8'h00);
    rd(3'd4, 8'h84, "R8");
    // R6 transmit enable off blocks clearing
    cur_req = "R6";
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h3C);
    rd(3'd4, 8'h80, "R6");
    wr(3'd4, 8'h00);
    idle();
    check("R6", {7'd0, last_txv}, 8'h00);
    rd(3'd4, 8'h80, "R6");
    cur_req = "R8";
    wr(3'd2, 8'h20);
    wr(3'd4, 8'h00);
    idle();
    check("R8", {7'd0, last_txv}, 8'h01);
    check("R8", last_txd, 8'h3C);
    rd(3'd4, 8'h84, "R12");
    // R9 receive path
    cur_req = "R9";
    rx(8'h11);
    rd(3'd4, 8'hC4, "R9");
    rd(3'd5, 8'h11, "R9");
    rd(3'd4, 8'h84, "R9");
    // R10 overrun
    cur_req = "R10";
    rx(8'h22);
    rx(8'h33);
    rd(3'd4, 8'hE4, "R10");
    rd(3'd5, 8'h22, "R10");
    rd(3'd4, 8'hA4, "R10");
    // R3 clear a seen overrun flag
    cur_req = "R3";
    wr(3'd4, 8'hDE);
    rd(3'd4, 8'h84, "R3");
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule